// File: doc/BRIEF.md
# Core Supply Regulator and Voltage Range Sequencer

This block is the digital control sequencer for a core supply rail. It chooses which regulator feeds the rail, either a linear regulator or a step-down converter. It also chooses the operating voltage range: range 1 for high performance, range 2 for low power. Software writes a requested regulator and range, which become the pending target. The sequencer compares the target against what is applied. It then runs a handshake with the analog side, one change at a time, and reports the applied regulator, the applied range and two ready flags.

A radio-activity input holds off the start of any change until the radio is asleep. A low-power exit event, tagged with its kind, restores the regulator and range that the exit type calls for. After a plain standby exit, the block automatically climbs back to the step-down converter when that was the target. A watchdog bounds every analog handshake. A missing acknowledge sets a sticky timeout flag and drops the pending change. A forced-PWM request for the step-down converter is passed through only while it can act.

Top module: `vcore_seq`

## Requirements
- R1: After reset the applied regulator is the linear one (0), the applied range is range 2 (0), both ready flags are 1, busy is 0 and the timeout flag is 0. Regulator encoding: 0 = linear, 1 = step-down. Range encoding: 0 = range 2, 1 = range 1.
- R2: A request equal to the applied regulator and range starts no sequence and leaves both ready flags at 1.
- R3: A range change first clears both ready flags. The request-ready flag sets on the clock edge that samples the range acknowledge. On the next edge the applied range takes the new value and the applied-ready flag sets.
- R4: While radio-active is high, no sequence starts and requests stay pending. The held sequence starts on the first edge at which radio-active is sampled low.
- R5: The regulator can switch in either direction in either range. The commanded regulator output changes when the sequence starts. The applied regulator changes only on the edge that samples the regulator acknowledge.
- R6: When both the regulator and the range differ from the target, the regulator is switched first and the range afterwards.
- R7: The low-power exit kind uses this encoding: 0 = Stop 0, 1 = Stop 1, 2 = standby with retention, 3 = plain standby. A Stop 0 exit keeps the applied range and regulator. A Stop 1 exit or a standby-with-retention exit forces the applied range and the pending range to range 2 and keeps the regulator.
- R8: A plain standby exit applies the linear regulator in range 2. It then switches automatically to the step-down converter if that is the pending target.
- R9: The forced-PWM output is 1 only when the forced-PWM enable is 1, range 1 is applied and the step-down converter is applied. In range 2 the enable has no effect.
- R10: If an acknowledge does not arrive within ACK_LIMIT cycles of waiting, the timeout flag sets and stays set until reset. The applied value is unchanged, the ready flags return to 1, and the pending change is dropped.
- R11: A request written while a sequence is running is latched. It starts once the running sequence completes.
- R12: A low-power exit aborts any running sequence. If a request write falls in the same cycle as a low-power exit, the written request becomes the pending target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_wr_i | input | 1 | One-cycle write strobe for the requested regulator and range |
| req_reg_i | input | 1 | Requested regulator (0 linear, 1 step-down) |
| req_rng_i | input | 1 | Requested range (0 range 2, 1 range 1) |
| fpwm_en_i | input | 1 | Forced-PWM enable for the step-down converter |
| radio_active_i | input | 1 | High while the radio is active and changes must wait |
| lp_exit_i | input | 1 | One-cycle low-power exit event |
| lp_kind_i | input | 2 | Kind of low-power exit (encoding in R7) |
| reg_ack_i | input | 1 | Analog acknowledge that the commanded regulator is in use |
| rng_ack_i | input | 1 | Analog acknowledge that the commanded range has settled |
| cmd_reg_o | output | 1 | Regulator commanded to the analog side |
| cmd_rng_o | output | 1 | Range commanded to the analog side |
| app_reg_o | output | 1 | Applied regulator status |
| app_rng_o | output | 1 | Applied range status |
| rdy_req_o | output | 1 | Range request ready flag |
| rdy_act_o | output | 1 | Applied range ready flag |
| busy_o | output | 1 | A sequence is in progress |
| fpwm_o | output | 1 | Forced-PWM control to the step-down converter |
| tmo_o | output | 1 | Sticky handshake timeout flag |

## Verification
A low-power exit and a software request write can land on the same clock edge. Both update the pending target, and the exit also aborts any handshake under way. The bench starts a range change with a slow acknowledge and, while it waits, drives a Stop 1 exit and a range-1 request in one cycle. It then checks that the applied range falls to range 2 at once with both ready flags set, and that a fresh sequence climbs back to range 1. A behavioural model steps through every cycle in parallel. It compares all status outputs after each edge, so a wrong priority shows up on the exact cycle where it happens.

// File: rtl/vcore_pkg.sv
package vcore_pkg;

    typedef enum logic {
        REG_LIN  = 1'b0,
        REG_BUCK = 1'b1
    } reg_sel_e;

    // RNG_LO is the low-power range (range 2), RNG_HI the performance range (range 1)
    typedef enum logic {
        RNG_LO = 1'b0,
        RNG_HI = 1'b1
    } rng_e;

    typedef enum logic [1:0] {
        LPX_STOP0    = 2'd0,
        LPX_STOP1    = 2'd1,
        LPX_STBY_RET = 2'd2,
        LPX_STBY     = 2'd3
    } lpx_e;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_REG_WAIT,
        SQ_RNG_WAIT,
        SQ_RNG_APPLY
    } sq_e;

    typedef struct packed {
        reg_sel_e regsel;
        rng_e     rng;
    } supply_t;

    localparam supply_t SUPPLY_RESET = '{regsel: REG_LIN, rng: RNG_LO};

    // every exit except the shallowest stop drops back to the low-power range
    function automatic logic lpx_forces_lo(lpx_e k);
        return k != LPX_STOP0;
    endfunction

    function automatic supply_t lpx_restore(supply_t cur, lpx_e k);
        supply_t r;
        r = cur;
        if (lpx_forces_lo(k)) r.rng = RNG_LO;
        if (k == LPX_STBY) r.regsel = REG_LIN;
        return r;
    endfunction

endpackage

// File: rtl/vcore_tgt_latch.sv
module vcore_tgt_latch
    import vcore_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    req_wr,
    input  supply_t req_val,
    input  logic    lp_exit,
    input  lpx_e    lp_kind,
    input  logic    drop_reg,
    input  logic    drop_rng,
    input  supply_t applied,
    output supply_t tgt
);

    // software write wins over exit forcing, which wins over a timeout drop
    always_ff @(posedge clk) begin
        if (rst) begin
            tgt <= SUPPLY_RESET;
        end else if (req_wr) begin
            tgt <= req_val;
        end else if (lp_exit) begin
            if (lpx_forces_lo(lp_kind)) tgt.rng <= RNG_LO;
        end else begin
            if (drop_reg) tgt.regsel <= applied.regsel;
            if (drop_rng) tgt.rng    <= applied.rng;
        end
    end

endmodule

// File: rtl/vcore_ack_wdog.sv
module vcore_ack_wdog #(
    parameter int unsigned LIMIT = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic expired
);

    localparam int unsigned CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (cnt != LAST) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign expired = run && (cnt == LAST);

endmodule

// File: rtl/vcore_seq.sv
module vcore_seq
    import vcore_pkg::*;
#(
    parameter int unsigned ACK_LIMIT = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       req_wr_i,
    input  logic       req_reg_i,
    input  logic       req_rng_i,
    input  logic       fpwm_en_i,
    input  logic       radio_active_i,
    input  logic       lp_exit_i,
    input  logic [1:0] lp_kind_i,
    input  logic       reg_ack_i,
    input  logic       rng_ack_i,
    output logic       cmd_reg_o,
    output logic       cmd_rng_o,
    output logic       app_reg_o,
    output logic       app_rng_o,
    output logic       rdy_req_o,
    output logic       rdy_act_o,
    output logic       busy_o,
    output logic       fpwm_o,
    output logic       tmo_o
);

    sq_e     st;
    supply_t app;
    supply_t cmd;
    supply_t tgt;
    supply_t lp_next;
    supply_t req_val;
    lpx_e    lp_kind;
    logic    rdy_req;
    logic    rdy_act;
    logic    tmo;
    logic    run;
    logic    expired;
    logic    drop_reg;
    logic    drop_rng;

    assign req_val  = '{regsel: reg_sel_e'(req_reg_i), rng: rng_e'(req_rng_i)};
    assign lp_kind  = lpx_e'(lp_kind_i);
    assign lp_next  = lpx_restore(app, lp_kind);
    assign run      = (st == SQ_REG_WAIT) || (st == SQ_RNG_WAIT);
    assign drop_reg = !lp_exit_i && (st == SQ_REG_WAIT) && !reg_ack_i && expired;
    assign drop_rng = !lp_exit_i && (st == SQ_RNG_WAIT) && !rng_ack_i && expired;

    vcore_tgt_latch u_tgt (
        .clk      (clk),
        .rst      (rst),
        .req_wr   (req_wr_i),
        .req_val  (req_val),
        .lp_exit  (lp_exit_i),
        .lp_kind  (lp_kind),
        .drop_reg (drop_reg),
        .drop_rng (drop_rng),
        .applied  (app),
        .tgt      (tgt)
    );

    vcore_ack_wdog #(.LIMIT(ACK_LIMIT)) u_wdog (
        .clk     (clk),
        .rst     (rst),
        .run     (run),
        .expired (expired)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= SQ_IDLE;
            app     <= SUPPLY_RESET;
            cmd     <= SUPPLY_RESET;
            rdy_req <= 1'b1;
            rdy_act <= 1'b1;
            tmo     <= 1'b0;
        end else if (lp_exit_i) begin
            // exit from low power overrides and abandons any handshake
            st      <= SQ_IDLE;
            app     <= lp_next;
            cmd     <= lp_next;
            rdy_req <= 1'b1;
            rdy_act <= 1'b1;
        end else begin
            if (drop_reg || drop_rng) tmo <= 1'b1;
            case (st)
                SQ_IDLE: begin
                    if (!radio_active_i) begin
                        if (tgt.regsel != app.regsel) begin
                            cmd.regsel <= tgt.regsel;
                            st         <= SQ_REG_WAIT;
                        end else if (tgt.rng != app.rng) begin
                            cmd.rng <= tgt.rng;
                            rdy_req <= 1'b0;
                            rdy_act <= 1'b0;
                            st      <= SQ_RNG_WAIT;
                        end
                    end
                end
                SQ_REG_WAIT: begin
                    if (reg_ack_i) begin
                        app.regsel <= cmd.regsel;
                        st         <= SQ_IDLE;
                    end else if (drop_reg) begin
                        cmd.regsel <= app.regsel;
                        st         <= SQ_IDLE;
                    end
                end
                SQ_RNG_WAIT: begin
                    if (rng_ack_i) begin
                        rdy_req <= 1'b1;
                        st      <= SQ_RNG_APPLY;
                    end else if (drop_rng) begin
                        cmd.rng <= app.rng;
                        rdy_req <= 1'b1;
                        rdy_act <= 1'b1;
                        st      <= SQ_IDLE;
                    end
                end
                SQ_RNG_APPLY: begin
                    app.rng <= cmd.rng;
                    rdy_act <= 1'b1;
                    st      <= SQ_IDLE;
                end
                default: st <= SQ_IDLE;
            endcase
        end
    end

    assign cmd_reg_o = cmd.regsel;
    assign cmd_rng_o = cmd.rng;
    assign app_reg_o = app.regsel;
    assign app_rng_o = app.rng;
    assign rdy_req_o = rdy_req;
    assign rdy_act_o = rdy_act;
    assign busy_o    = (st != SQ_IDLE);
    assign tmo_o     = tmo;
    assign fpwm_o    = fpwm_en_i && (app.rng == RNG_HI) && (app.regsel == REG_BUCK);

    AST_EQ_NO_SEQ: assert property (@(posedge clk) disable iff (rst)
        (st == SQ_IDLE && tgt == app && !lp_exit_i) |=> (st == SQ_IDLE)) else $error("request equal to applied started a sequence"); // R2

    AST_RANGE_TWO_STEP: assert property (@(posedge clk) disable iff (rst)
        (!$past(lp_exit_i) && app.rng != $past(app.rng)) |-> (rdy_act && $past(rdy_req) && !$past(rdy_act))) else $error("applied range moved without two-step ready"); // R3

    AST_RADIO_HOLD: assert property (@(posedge clk) disable iff (rst)
        (st == SQ_IDLE && radio_active_i && !lp_exit_i) |=> (st == SQ_IDLE)) else $error("sequence started while radio active"); // R4

    AST_REG_AFTER_ACK: assert property (@(posedge clk) disable iff (rst)
        (!$past(lp_exit_i) && app.regsel != $past(app.regsel)) |-> $past(reg_ack_i)) else $error("regulator status changed without acknowledge"); // R5

    AST_STOP0_KEEP: assert property (@(posedge clk) disable iff (rst)
        (lp_exit_i && lp_kind == LPX_STOP0) |=> (app == $past(app))) else $error("shallow stop exit changed supply"); // R7

    AST_STBY_LIN: assert property (@(posedge clk) disable iff (rst)
        (lp_exit_i && lp_kind == LPX_STBY) |=> (app.regsel == REG_LIN && app.rng == RNG_LO)) else $error("standby exit not on linear regulator in range 2"); // R8

    AST_TMO_STICKY: assert property (@(posedge clk) disable iff (rst)
        tmo |=> tmo) else $error("timeout flag cleared"); // R10

endmodule

// File: tb/vcore_seq_tb_top.sv
module vcore_seq_tb_top;

    localparam int LIMIT = 12;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst = 1'b1, req_wr = 1'b0, req_reg = 1'b0, req_rng = 1'b0;
    logic fpwm_en = 1'b0, radio = 1'b0, lp_exit = 1'b0;
    logic reg_ack = 1'b0, rng_ack = 1'b0;
    logic [1:0] lp_kind = 2'd0;
    logic cmd_reg_o, cmd_rng_o, app_reg_o, app_rng_o, rdy_req_o, rdy_act_o;
    logic busy_o, fpwm_o, tmo_o;

    vcore_seq #(.ACK_LIMIT(LIMIT)) dut_i (
        .clk(clk), .rst(rst), .req_wr_i(req_wr), .req_reg_i(req_reg), .req_rng_i(req_rng),
        .fpwm_en_i(fpwm_en), .radio_active_i(radio), .lp_exit_i(lp_exit), .lp_kind_i(lp_kind),
        .reg_ack_i(reg_ack), .rng_ack_i(rng_ack), .cmd_reg_o(cmd_reg_o), .cmd_rng_o(cmd_rng_o),
        .app_reg_o(app_reg_o), .app_rng_o(app_rng_o), .rdy_req_o(rdy_req_o), .rdy_act_o(rdy_act_o),
        .busy_o(busy_o), .fpwm_o(fpwm_o), .tmo_o(tmo_o)
    );

    int checks = 0, fails = 0, cyc = 0;

    // behavioural reference: phase 0 idle, 1 regulator wait, 2 range wait, 3 range apply
    int m_reg, m_rng, m_creg, m_crng, m_rq, m_ra, m_tmo, m_treg, m_trng, m_ph, m_wait;
    int n_treg, n_trng, n_wait, to;

    always @(posedge clk) begin
        cyc++;
        if (rst) begin
            m_reg = 0; m_rng = 0; m_creg = 0; m_crng = 0; m_rq = 1; m_ra = 1;
            m_tmo = 0; m_treg = 0; m_trng = 0; m_ph = 0; m_wait = 0;
        end else begin
            to = 0;
            if (!lp_exit && m_wait == LIMIT - 1 &&
                ((m_ph == 1 && !reg_ack) || (m_ph == 2 && !rng_ack))) to = 1;
            n_treg = m_treg; n_trng = m_trng;
            if (to && m_ph == 1) n_treg = m_reg;
            if (to && m_ph == 2) n_trng = m_rng;
            if (lp_exit && lp_kind != 2'd0) n_trng = 0;
            if (req_wr) begin n_treg = req_reg; n_trng = req_rng; end
            n_wait = (m_ph == 1 || m_ph == 2) ? m_wait + 1 : 0;
            if (lp_exit) begin
                if (lp_kind != 2'd0) m_rng = 0;
                if (lp_kind == 2'd3) m_reg = 0;
                m_creg = m_reg; m_crng = m_rng; m_rq = 1; m_ra = 1; m_ph = 0;
            end else begin
                if (to) m_tmo = 1;
                case (m_ph)
                    0: if (!radio) begin
                        if (m_treg != m_reg) begin m_creg = m_treg; m_ph = 1; end
                        else if (m_trng != m_rng) begin m_crng = m_trng; m_rq = 0; m_ra = 0; m_ph = 2; end
                    end
                    1: if (reg_ack) begin m_reg = m_creg; m_ph = 0; end
                       else if (to) begin m_creg = m_reg; m_ph = 0; end
                    2: if (rng_ack) begin m_rq = 1; m_ph = 3; end
                       else if (to) begin m_crng = m_rng; m_rq = 1; m_ra = 1; m_ph = 0; end
                    default: begin m_rng = m_crng; m_ra = 1; m_ph = 0; end
                endcase
            end
            m_treg = n_treg; m_trng = n_trng; m_wait = n_wait;
        end
    end

    task automatic cmp(input int act, input int exp, input string tag);
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic dchk(input int act, input int exp, input string tag);
        checks++;
        cmp(act, exp, tag);
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    // per-cycle comparison, sampled between edges
    always @(posedge clk) begin
        #3;
        if (!rst) begin
            checks++;
            cmp(app_reg_o, m_reg, "R5 applied regulator");
            cmp(cmd_reg_o, m_creg, "R5 commanded regulator");
            cmp(app_rng_o, m_rng, "R3 applied range");
            cmp(cmd_rng_o, m_crng, "R3 commanded range");
            cmp(rdy_req_o, m_rq, "R3 request ready");
            cmp(rdy_act_o, m_ra, "R3 applied ready");
            cmp(busy_o, (m_ph != 0) ? 1 : 0, "R11 busy");
            cmp(tmo_o, m_tmo, "R10 timeout flag");
            cmp(fpwm_o, (fpwm_en && m_rng == 1 && m_reg == 1) ? 1 : 0, "R9 forced PWM");
        end
        if (cyc > 20000) begin
            fails++;
            $display("FAIL R11 watchdog actual=%0d expected<20000", cyc);
            finish_run();
        end
    end

    // analog responder: acknowledges after ack_dly cycles of waiting
    int   ack_dly = 2;
    logic ack_on  = 1'b1;
    int   rcnt = 0, gcnt = 0;
    always @(negedge clk) begin
        if (ack_on && !rst && (cmd_reg_o != app_reg_o)) begin
            reg_ack = (rcnt == ack_dly); rcnt++;
        end else begin
            reg_ack = 1'b0; rcnt = 0;
        end
        if (ack_on && !rst && !rdy_req_o) begin
            rng_ack = (gcnt == ack_dly); gcnt++;
        end else begin
            rng_ack = 1'b0; gcnt = 0;
        end
    end

    task automatic tick(input int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic request(input logic r, input logic g);
        req_reg = r; req_rng = g; req_wr = 1'b1;
        tick();
        req_wr = 1'b0;
    endtask

    task automatic lpx(input logic [1:0] k);
        lp_kind = k; lp_exit = 1'b1;
        tick();
        lp_exit = 1'b0;
    endtask

    task automatic settle();
        int quiet = 0;
        tick(2);
        for (int i = 0; i < 400 && quiet < 3; i++) begin
            if (busy_o) quiet = 0; else quiet++;
            tick();
        end
    endtask

    initial begin
        tick(3);
        rst = 1'b0;
        tick();
        // R1 reset state
        dchk(app_reg_o, 0, "R1 reset regulator");
        dchk(app_rng_o, 0, "R1 reset range");
        dchk(rdy_req_o, 1, "R1 reset request ready");
        dchk(rdy_act_o, 1, "R1 reset applied ready");
        dchk(busy_o, 0, "R1 reset busy");
        dchk(tmo_o, 0, "R1 reset timeout");

        // R2 equal request
        request(1'b0, 1'b0);
        tick(3);
        dchk(busy_o, 0, "R2 no sequence");
        dchk(rdy_req_o, 1, "R2 request ready kept");
        dchk(rdy_act_o, 1, "R2 applied ready kept");

        // R5 linear to step-down in range 2
        request(1'b1, 1'b0);
        settle();
        dchk(app_reg_o, 1, "R5 switch to step-down");

        // R3 two-step range raise
        request(1'b1, 1'b1);
        tick();
        dchk(rdy_req_o, 0, "R3 request ready cleared");
        dchk(rdy_act_o, 0, "R3 applied ready cleared");
        for (int i = 0; i < 50 && !rdy_req_o; i++) tick();
        dchk(rdy_act_o, 0, "R3 applied ready still low at step one");
        dchk(app_rng_o, 0, "R3 range not yet applied at step one");
        tick();
        dchk(rdy_act_o, 1, "R3 applied ready at step two");
        dchk(app_rng_o, 1, "R3 range applied at step two");

        // R9 forced PWM
        fpwm_en = 1'b1;
        tick();
        dchk(fpwm_o, 1, "R9 active in range 1");
        request(1'b1, 1'b0);
        settle();
        dchk(app_rng_o, 0, "R9 back in range 2");
        dchk(fpwm_o, 0, "R9 ignored in range 2");

        // R4 radio hold
        radio = 1'b1;
        request(1'b1, 1'b1);
        tick(8);
        dchk(busy_o, 0, "R4 held while radio active");
        dchk(app_rng_o, 0, "R4 range unchanged while held");
        radio = 1'b0;
        tick();
        dchk(busy_o, 1, "R4 started once radio asleep");
        settle();
        dchk(app_rng_o, 1, "R4 pending range applied");

        // R6 regulator before range
        request(1'b0, 1'b0);
        for (int i = 0; i < 50 && app_reg_o; i++) tick();
        dchk(app_rng_o, 1, "R6 range still high when regulator switched");
        settle();
        dchk(app_rng_o, 0, "R6 range lowered afterwards");

        // R11 request during a sequence
        request(1'b0, 1'b1);
        tick(2);
        dchk(busy_o, 1, "R11 first sequence running");
        request(1'b1, 1'b1);
        settle();
        dchk(app_reg_o, 1, "R11 latched regulator applied");
        dchk(app_rng_o, 1, "R11 range kept");

        // R7 exits
        lpx(2'd0);
        dchk(app_rng_o, 1, "R7 stop0 keeps range");
        dchk(app_reg_o, 1, "R7 stop0 keeps regulator");
        lpx(2'd1);
        dchk(app_rng_o, 0, "R7 stop1 forces range 2");
        dchk(app_reg_o, 1, "R7 stop1 keeps regulator");
        tick(3);
        dchk(busy_o, 0, "R7 pending range forced to range 2");
        request(1'b1, 1'b1);
        settle();
        lpx(2'd2);
        dchk(app_rng_o, 0, "R7 retention standby forces range 2");
        dchk(app_reg_o, 1, "R7 retention standby keeps regulator");

        // R8 plain standby
        request(1'b1, 1'b1);
        settle();
        lpx(2'd3);
        dchk(app_reg_o, 0, "R8 standby exit on linear");
        dchk(app_rng_o, 0, "R8 standby exit in range 2");
        tick();
        dchk(busy_o, 1, "R8 automatic switch started");
        settle();
        dchk(app_reg_o, 1, "R8 back on step-down");
        dchk(app_rng_o, 0, "R8 stays in range 2");

        // R10 timeout
        ack_on = 1'b0;
        request(1'b0, 1'b0);
        tick(LIMIT + 4);
        dchk(tmo_o, 1, "R10 timeout set");
        dchk(app_reg_o, 1, "R10 applied regulator unchanged");
        dchk(busy_o, 0, "R10 sequence ended");
        tick(4);
        dchk(busy_o, 0, "R10 pending change dropped");
        ack_on = 1'b1;
        request(1'b1, 1'b1);
        settle();
        dchk(app_rng_o, 1, "R10 later sequence works");
        dchk(tmo_o, 1, "R10 timeout sticky");

        // R12 exit and request in the same cycle during a handshake
        ack_dly = 6;
        request(1'b1, 1'b0);
        tick(3);
        dchk(busy_o, 1, "R12 range sequence in progress");
        lp_kind = 2'd1; lp_exit = 1'b1;
        req_reg = 1'b1; req_rng = 1'b1; req_wr = 1'b1;
        tick();
        lp_exit = 1'b0; req_wr = 1'b0;
        dchk(app_rng_o, 0, "R12 exit aborts to range 2");
        dchk(rdy_req_o, 1, "R12 request ready after abort");
        dchk(rdy_act_o, 1, "R12 applied ready after abort");
        tick();
        dchk(busy_o, 1, "R12 written request drives new sequence");
        settle();
        dchk(app_rng_o, 1, "R12 written request wins");
        ack_dly = 2;

        tick(2);
        finish_run();
    end

endmodule